// File: doc/BRIEF.md
# Flash Read Accelerator with Programmable Wait States

This block sits between a CPU read port and a slow flash array. It keeps recently fetched flash lines in a small set of holding latches. Repeated or sequential reads can then be answered without waiting for the flash. A flash line holds `WPL` data words. The CPU addresses single words. The flash side always moves a whole line.

Two software registers control the block. A 2-bit mode field turns acceleration off, partly on, or fully on. A 3-bit timing field sets how many clock cycles one flash access takes. In full mode the block also fetches the next line in the background after the CPU hits the current line.

The CPU port works as follows. The CPU holds `cpu_req_i` and its address until `cpu_ready_o` is high. The read completes in that cycle.

The flash port works as follows. The block holds `flash_rd_o` and the line address for exactly the programmed number of cycles. It captures `flash_rdata_i` in the last of those cycles.

Top module: `flash_accel`

## Requirements
- R1: After reset the mode field and the timing field both read 0, `cpu_ready_o` is low while no request is pending, and `flash_rd_o` is low.
- R2: Mode is written at byte offset 0x0 in bits [1:0]. The codes are 00 off, 01 partial and 10 full. A write of 11 is ignored: the previous mode stays and the latches are not flushed.
- R3: Timing is written at byte offset 0x4 in bits [2:0]. Unused register bits read as 0. Values 1 to 7 give that many flash cycles per access, and 0 gives 7. A read that misses completes exactly that many cycles after the request is accepted.
- R4: In off mode every read, including a repeated read of the same address, starts a flash access.
- R5: In partial mode a sequential instruction fetch (`cpu_instr_i`=1, `cpu_seq_i`=1) whose line is latched completes in the request cycle. Data reads and non-sequential fetches always start a flash access.
- R6: In full mode any read whose line is held in a valid latch completes in the request cycle with the latched word, and `cpu_ready_o` is only high while a request is present.
- R7: In full mode a hit on line L, with the flash idle and L+1 not latched, starts a background flash access of line L+1. A later read of L+1 then completes in the request cycle.
- R8: A mode write that changes the mode invalidates all latches, including a fill still in flight. The next read returns fresh flash data through a flash access.
- R9: A timing write keeps all latches valid and applies from the next flash access that starts.
- R10: A demand miss that arrives during a background prefetch waits for the prefetch to finish, then starts its own access. The prefetched line stays usable.
- R11: While `flash_rd_o` is high, `flash_addr_o` holds the line being read, and an access is never longer than 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte offset (0x0 mode, 0x4 timing) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| cpu_req_i | input | 1 | CPU read request, held until ready |
| cpu_addr_i | input | AW | CPU word address |
| cpu_instr_i | input | 1 | Request is an instruction fetch |
| cpu_seq_i | input | 1 | Fetch follows the previous fetch sequentially |
| cpu_ready_o | output | 1 | Read completes this cycle |
| cpu_rdata_o | output | DATA_W | Read word, valid with `cpu_ready_o` |
| flash_rd_o | output | 1 | Flash access in progress |
| flash_addr_o | output | AW-log2(WPL) | Line address of the access |
| flash_rdata_i | input | DATA_W*WPL | Flash line data, captured in the last access cycle |

## Verification
A CPU demand read and a background prefetch can both need the single flash port in the same cycle. The bench provokes this in full mode with 7-cycle timing. It hits a line so that the next line starts prefetching, and two cycles later it issues a miss to an unrelated line. It judges the outcome by the exact miss latency, which is the prefetch remainder plus one idle cycle plus a full access (13 cycles from the request). It also checks the returned data, and checks that the prefetched line then hits in zero cycles. A mode change that arrives during an in-flight access is covered by the flush check on the latch state.

// File: rtl/flash_accel_pkg.sv
package flash_accel_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_PART = 2'b01,
    MODE_FULL = 2'b10
  } mode_e;

  localparam int unsigned REG_DW = 32;
  localparam logic [2:0]  OFF_MODE = 3'h0;
  localparam logic [2:0]  OFF_TIM  = 3'h4;

  // zero timing selects the slowest access
  function automatic logic [2:0] eff_cycles(logic [2:0] t);
    return (t == 3'd0) ? 3'd7 : t;
  endfunction
endpackage

// File: rtl/flash_accel_regs.sv
module flash_accel_regs
  import flash_accel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output mode_e             mode_o,
  output logic [2:0]        tim_o,
  output logic              flush_o
);
  mode_e      mode_q;
  logic [2:0] tim_q;
  logic       mode_wr, mode_legal;
  logic [REG_DW-4:0] wdata_unused;

  assign wdata_unused = wdata_i[REG_DW-1:3];
  assign mode_wr    = we_i && (addr_i == OFF_MODE);
  assign mode_legal = (wdata_i[1:0] != 2'b11);
  assign flush_o    = mode_wr && mode_legal && (wdata_i[1:0] != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      tim_q  <= 3'd0;
    end else begin
      if (mode_wr && mode_legal) mode_q <= mode_e'(wdata_i[1:0]);
      if (we_i && (addr_i == OFF_TIM)) tim_q <= wdata_i[2:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFF_MODE)     rdata_o = REG_DW'(mode_q);
    else if (addr_i == OFF_TIM) rdata_o = REG_DW'(tim_q);
  end

  assign mode_o = mode_q;
  assign tim_o  = tim_q;
endmodule

// File: rtl/flash_accel_lines.sv
module flash_accel_lines #(
  parameter int unsigned NUM_LAT = 2,
  parameter int unsigned LAW     = 10,
  parameter int unsigned LINE_W  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fill_i,
  input  logic [LAW-1:0]    fill_tag_i,
  input  logic [LINE_W-1:0] fill_data_i,
  input  logic [LAW-1:0]    look_tag_i,
  input  logic [LAW-1:0]    next_tag_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] hit_line_o,
  output logic              next_hit_o,
  output logic [NUM_LAT-1:0] valid_o
);
  localparam int unsigned PW = (NUM_LAT > 1) ? $clog2(NUM_LAT) : 1;

  logic [NUM_LAT-1:0] valid_q, hit_v, next_v;
  logic [LAW-1:0]     tag_q  [NUM_LAT];
  logic [LINE_W-1:0]  data_q [NUM_LAT];
  logic [PW-1:0]      ptr_q;

  for (genvar i = 0; i < NUM_LAT; i++) begin : g_cmp
    assign hit_v[i]  = valid_q[i] && (tag_q[i] == look_tag_i);
    assign next_v[i] = valid_q[i] && (tag_q[i] == next_tag_i);
  end

  always_comb begin
    hit_line_o = '0;
    for (int i = 0; i < NUM_LAT; i++)
      if (hit_v[i]) hit_line_o = data_q[i];
  end

  assign hit_o      = |hit_v;
  assign next_hit_o = |next_v;
  assign valid_o    = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_LAT; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_i) begin
      for (int i = 0; i < NUM_LAT; i++)
        if (ptr_q == PW'(i)) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= fill_tag_i;
          data_q[i]  <= fill_data_i;
        end
    end
  end

  // round-robin victim
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (flush_i) ptr_q <= '0;
    else if (fill_i)  ptr_q <= (ptr_q == PW'(NUM_LAT - 1)) ? '0 : ptr_q + PW'(1);
  end
endmodule

// File: rtl/flash_accel_seq.sv
module flash_accel_seq
  import flash_accel_pkg::*;
#(
  parameter int unsigned LAW = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [LAW-1:0] start_addr_i,
  input  logic           start_demand_i,
  input  logic           start_fill_i,
  input  logic [2:0]     tim_i,
  input  logic           flush_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           demand_o,
  output logic           fill_o,
  output logic [LAW-1:0] addr_o
);
  logic           busy_q, dem_q, fill_q;
  logic [2:0]     cnt_q, lim_q;
  logic [LAW-1:0] addr_q;

  assign done_o   = busy_q && (cnt_q == lim_q);
  assign busy_o   = busy_q;
  assign demand_o = dem_q;
  assign fill_o   = done_o && fill_q;
  assign addr_o   = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= 3'd0;
      lim_q  <= 3'd7;
      addr_q <= '0;
      dem_q  <= 1'b0;
      fill_q <= 1'b0;
    end else begin
      if (busy_q) begin
        if (done_o) busy_q <= 1'b0;
        else        cnt_q  <= cnt_q + 3'd1;
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= 3'd1;
        lim_q  <= eff_cycles(tim_i);
        addr_q <= start_addr_i;
        dem_q  <= start_demand_i;
        fill_q <= start_fill_i;
      end
      if (flush_i) fill_q <= 1'b0; // drop in-flight fill
    end
  end
endmodule

// File: rtl/flash_accel.sv
module flash_accel
  import flash_accel_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WPL     = 4,
  parameter int unsigned AW      = 12,
  parameter int unsigned NUM_LAT = 2,
  localparam int unsigned OFF_W  = $clog2(WPL),
  localparam int unsigned LAW    = AW - OFF_W,
  localparam int unsigned LINE_W = DATA_W * WPL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              cpu_req_i,
  input  logic [AW-1:0]     cpu_addr_i,
  input  logic              cpu_instr_i,
  input  logic              cpu_seq_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              flash_rd_o,
  output logic [LAW-1:0]    flash_addr_o,
  input  logic [LINE_W-1:0] flash_rdata_i
);
  mode_e              mode_w;
  logic [2:0]         tim_w;
  logic               flush_w;
  logic [LAW-1:0]     cpu_line, next_line, acc_addr;
  logic [OFF_W-1:0]   cpu_off;
  logic               hit_w, next_hit_w, hit_ok, serve_hit;
  logic               busy_w, done_w, dem_w, fill_w, demand_busy;
  logic               start_dem, start_pf, start_fill;
  logic [LINE_W-1:0]  hit_line, src_line;
  logic [NUM_LAT-1:0] valid_w;

  assign cpu_line  = cpu_addr_i[AW-1:OFF_W];
  assign cpu_off   = cpu_addr_i[OFF_W-1:0];
  assign next_line = cpu_line + LAW'(1);

  flash_accel_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .mode_o(mode_w), .tim_o(tim_w), .flush_o(flush_w)
  );

  flash_accel_lines #(.NUM_LAT(NUM_LAT), .LAW(LAW), .LINE_W(LINE_W)) u_lines (
    .clk_i, .rst_ni,
    .flush_i(flush_w), .fill_i(fill_w), .fill_tag_i(acc_addr), .fill_data_i(flash_rdata_i),
    .look_tag_i(cpu_line), .next_tag_i(next_line),
    .hit_o(hit_w), .hit_line_o(hit_line), .next_hit_o(next_hit_w), .valid_o(valid_w)
  );

  // latch use permitted by mode and access kind
  assign hit_ok = (mode_w == MODE_FULL) ||
                  ((mode_w == MODE_PART) && cpu_instr_i && cpu_seq_i);
  assign demand_busy = busy_w && dem_w;
  assign serve_hit   = cpu_req_i && hit_ok && hit_w && !demand_busy;
  assign start_dem   = cpu_req_i && !serve_hit && !busy_w;
  assign start_pf    = serve_hit && (mode_w == MODE_FULL) && !busy_w && !next_hit_w;
  assign start_fill  = start_pf || (mode_w == MODE_FULL) ||
                       ((mode_w == MODE_PART) && cpu_instr_i);

  flash_accel_seq #(.LAW(LAW)) u_seq (
    .clk_i, .rst_ni,
    .start_i(start_dem || start_pf),
    .start_addr_i(start_pf ? next_line : cpu_line),
    .start_demand_i(start_dem),
    .start_fill_i(start_fill),
    .tim_i(tim_w), .flush_i(flush_w),
    .busy_o(busy_w), .done_o(done_w), .demand_o(dem_w), .fill_o(fill_w), .addr_o(acc_addr)
  );

  assign src_line     = serve_hit ? hit_line : flash_rdata_i;
  assign cpu_rdata_o  = src_line[cpu_off*DATA_W +: DATA_W];
  assign cpu_ready_o  = serve_hit || (done_w && dem_w);
  assign flash_rd_o   = busy_w;
  assign flash_addr_o = acc_addr;
endmodule

// File: rtl/flash_accel_sva.sv
module flash_accel_sva #(
  parameter int unsigned LAW     = 10,
  parameter int unsigned NUM_LAT = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cpu_req_i,
  input logic               cpu_ready_o,
  input logic               flash_rd_o,
  input logic [LAW-1:0]     flash_addr_o,
  input logic [1:0]         mode_q,
  input logic [NUM_LAT-1:0] valid_q
);
  logic [3:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (!flash_rd_o) run_q <= '0;
    else if (run_q != 4'hf) run_q <= run_q + 4'd1;
  end

  p_mode_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b11);

  p_ready_has_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> cpu_req_i);

  p_off_via_flash_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && mode_q == 2'b00) |-> flash_rd_o);

  p_addr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_rd_o && $past(flash_rd_o)) |-> $stable(flash_addr_o));

  p_access_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_rd_o |-> (run_q < 4'd7));

  p_flush_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> (valid_q == '0));
endmodule

bind flash_accel flash_accel_sva #(.LAW(LAW), .NUM_LAT(NUM_LAT)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_ready_o(cpu_ready_o),
  .flash_rd_o(flash_rd_o), .flash_addr_o(flash_addr_o),
  .mode_q(mode_w), .valid_q(valid_w)
);

// File: tb/sim_flash_accel.sv
`timescale 1ns/1ps
module sim_flash_accel;
  localparam int DATA_W = 32, WPL = 4, AW = 12, LAW = 10, LINE_W = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cpu_req = 1'b0, cpu_instr = 1'b0, cpu_seq = 1'b0, cpu_ready;
  logic [AW-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic flash_rd;
  logic [LAW-1:0] flash_addr;
  logic [LINE_W-1:0] flash_rdata;
  logic [7:0] gen = '0;

  int vectors = 0, errors = 0, starts = 0;
  logic prev_rd = 1'b0;
  logic [LAW-1:0] last_addr = '0;

  always #10 clk = ~clk; // 50 MHz

  flash_accel u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cpu_req_i(cpu_req),
    .cpu_addr_i(cpu_addr), .cpu_instr_i(cpu_instr), .cpu_seq_i(cpu_seq),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata), .flash_rd_o(flash_rd),
    .flash_addr_o(flash_addr), .flash_rdata_i(flash_rdata)
  );

  function automatic logic [31:0] word_of(logic [AW-1:0] a, logic [7:0] g);
    return 32'h5A5A_0000 ^ 32'(a) ^ ({24'h0, g} << 24);
  endfunction

  always_comb
    for (int w = 0; w < WPL; w++)
      flash_rdata[w*DATA_W +: DATA_W] = word_of({flash_addr, 2'(w)}, gen);

  always @(negedge clk) begin
    if (flash_rd && !prev_rd) begin
      starts++;
      last_addr = flash_addr;
    end
    prev_rd = flash_rd;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cpu_read(logic [AW-1:0] a, logic ins, logic sq,
                          output logic [31:0] d, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a; cpu_instr = ins; cpu_seq = sq;
    #1 lat = 0;
    while (!cpu_ready && lat < 40) begin
      @(negedge clk); lat++;
    end
    d = cpu_rdata;
    @(negedge clk); cpu_req = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'h0, d); chk("R1 mode", d, 0);
    rd(3'h4, d); chk("R1 timing", d, 0);
    chk("R1 ready", 32'(cpu_ready), 0);
    chk("R1 flash_rd", 32'(flash_rd), 0);
  endtask

  task automatic t_off();
    logic [31:0] d; int lat, s0;
    wr(3'h4, 2);
    s0 = starts;
    cpu_read(12'h040, 1, 1, d, lat);
    chk("R4 lat1", lat, 2); chk("R4 data", d, word_of(12'h040, gen));
    cpu_read(12'h040, 1, 1, d, lat);
    chk("R4 lat2", lat, 2);
    chk("R4 accesses", starts - s0, 2);
    chk("R11 addr", 32'(last_addr), 32'h010);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3'h0, 32'hFFFF_FFF1); rd(3'h0, d); chk("R2 mode partial", d, 1);
    wr(3'h0, 32'h3);         rd(3'h0, d); chk("R2 mode 11 ignored", d, 1);
    wr(3'h4, 32'hFFFF_FFFA); rd(3'h4, d); chk("R3 timing unused zero", d, 2);
  endtask

  task automatic t_partial();
    logic [31:0] d; int lat;
    wr(3'h4, 3);
    cpu_read(12'h080, 1, 0, d, lat); chk("R5 nonseq miss", lat, 3);
    cpu_read(12'h081, 1, 1, d, lat); chk("R5 seq hit", lat, 0);
    chk("R5 seq data", d, word_of(12'h081, gen));
    cpu_read(12'h082, 0, 0, d, lat); chk("R5 data read flash", lat, 3);
    cpu_read(12'h083, 1, 0, d, lat); chk("R5 nonseq flash", lat, 3);
    wr(3'h0, 32'h3);
    cpu_read(12'h081, 1, 1, d, lat); chk("R2 no flush on 11", lat, 0);
  endtask

  task automatic t_timing();
    logic [31:0] d; int lat;
    wr(3'h0, 2); wr(3'h4, 0);
    cpu_read(12'h100, 0, 0, d, lat); chk("R3 zero is 7", lat, 7);
    wr(3'h4, 1);
    cpu_read(12'h101, 0, 0, d, lat); chk("R9 kept latch", lat, 0);
    cpu_read(12'h200, 0, 0, d, lat); chk("R9 new timing", lat, 1);
    chk("R3 data", d, word_of(12'h200, gen));
    wr(3'h4, 3);
    cpu_read(12'h300, 0, 0, d, lat); chk("R3 timing 3", lat, 3);
  endtask

  task automatic t_prefetch();
    logic [31:0] d; int lat, s0;
    wr(3'h4, 4); wr(3'h0, 1); wr(3'h0, 2);
    cpu_read(12'h400, 0, 0, d, lat); chk("R6 miss", lat, 4);
    s0 = starts;
    cpu_read(12'h402, 1, 0, d, lat); chk("R6 any read hits", lat, 0);
    chk("R6 data", d, word_of(12'h402, gen));
    repeat (8) @(negedge clk);
    chk("R7 one prefetch", starts - s0, 1);
    chk("R7 next line", 32'(last_addr), 32'h101);
    cpu_read(12'h404, 0, 0, d, lat); chk("R7 prefetched hit", lat, 0);
    chk("R7 data", d, word_of(12'h404, gen));
    repeat (8) @(negedge clk);
  endtask

  task automatic t_overlap();
    logic [31:0] d; int lat;
    wr(3'h4, 7); wr(3'h0, 1); wr(3'h0, 2);
    cpu_read(12'h800, 0, 0, d, lat); chk("R10 first miss", lat, 7);
    cpu_read(12'h801, 0, 0, d, lat); chk("R10 hit", lat, 0);
    cpu_read(12'hC00, 0, 0, d, lat); chk("R10 waits for prefetch", lat, 13);
    chk("R10 data", d, word_of(12'hC00, gen));
    chk("R11 demand addr", 32'(last_addr), 32'h300);
    cpu_read(12'h804, 0, 0, d, lat); chk("R10 prefetch kept", lat, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_flush();
    logic [31:0] d; int lat;
    wr(3'h4, 2);
    cpu_read(12'h900, 0, 0, d, lat); chk("R8 fill", lat, 2);
    gen = 8'h01;
    cpu_read(12'h900, 0, 0, d, lat); chk("R8 stale hit", d, word_of(12'h900, 8'h00));
    repeat (4) @(negedge clk);
    wr(3'h0, 1);
    cpu_read(12'h901, 1, 1, d, lat); chk("R8 flushed lat", lat, 2);
    chk("R8 fresh data", d, word_of(12'h901, gen));
    wr(3'h0, 2);
    cpu_read(12'h901, 0, 0, d, lat); chk("R8 second flush", lat, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_off();
    t_regs();
    t_partial();
    t_timing();
    t_prefetch();
    t_overlap();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule